// File: doc/BRIEF.md
# I2C Read-Only Target with Clock Stretching

This block is an I2C target that only answers read requests. It watches the bus through synchronizers on the system clock and recognises START and STOP conditions. It collects the 7-bit address together with the direction bit. When the address is its own and the direction is read, it acknowledges. From then on it serves data bytes that a local host supplies one at a time.

Before every byte it sends, the target stretches the clock by holding SCL low. The host reads the flags, clears the per-byte interrupt and loads the next byte into the buffer. It then sets the release bit. The byte goes out MSB first, with SDA changing only while SCL is low. The master's acknowledge bit decides what happens next. An ACK leads to another stretch. A NACK ends the transfer, and the target then waits for a new START.

Top module: `i2c_rd_slave`

## Requirements
- R1: While reset is active and right after it, both open-drain drive outputs are 0 (lines released), and `rw_flag`, `buf_full` and `irq_flag` are 0.
- R2: A START is SDA falling while SCL has been high on two consecutive synchronized samples. A STOP is SDA rising under the same SCL condition. A START from any state restarts address collection. A STOP returns the engine to waiting for START.
- R3: The address byte is sampled MSB first on rising SCL. The engine answers only when bits [7:1] equal `own_addr` and bit 0 is 1 (read). It answers by driving `sda_drive_low` = 1 through the ninth clock, so the wired-AND line reads 0. Any other byte gets no acknowledge, and the engine ignores the bus until the next START.
- R4: On an address match, `rw_flag` becomes 1 and `buf_rdata` holds the received address byte ({own_addr, 1}).
- R5: From the falling edge that ends the ninth clock of the matched address, `scl_drive_low` stays 1.
- R6: The SCL hold is released only by a `rel_set` pulse while `buf_full` is 1. A `rel_set` pulse while `buf_full` is 0 leaves `scl_drive_low` at 1.
- R7: A `buf_wr` pulse while SCL is held loads `buf_wdata` into the buffer and the transmit shifter and sets `buf_full` to 1. `buf_full` returns to 0 on the SCL falling edge that ends bit D0.
- R8: `irq_flag` sets on the falling edge of the ninth SCL pulse of the acknowledged address and of every data byte, whether the master sent ACK or NACK. It stays set until an `irq_clr` pulse. A set in the same cycle takes priority over the clear.
- R9: Data bits leave MSB first. `sda_drive_low` changes only while the synchronized SCL is low, so SDA is stable for the whole SCL high time.
- R10: The master's acknowledge is captured on the ninth rising SCL edge of each data byte. If it was 0 (ACK), SCL is held low again from the ninth falling edge.
- R11: If the captured acknowledge was 1 (NACK), SCL is not held at the ninth falling edge. `rw_flag` and `buf_full` go to 0, and only a START restarts the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| buf_wr | input | 1 | Host strobe that loads the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| rel_set | input | 1 | Host strobe that releases the stretched SCL |
| irq_clr | input | 1 | Host strobe that clears the interrupt flag |
| buf_rdata | output | 8 | Buffer contents (received address, then the loaded byte) |
| rw_flag | output | 1 | 1 while a matched read transfer is active |
| buf_full | output | 1 | 1 while a loaded byte has not been fully sent |
| irq_flag | output | 1 | Per-byte interrupt flag |

## Verification
Some rules are checked by the assertions on every cycle. SDA may only move while the synchronized SCL is low, except when a bus condition aborts the transfer. The interrupt may only rise on a falling SCL edge. The stretch must persist until a qualified release, and `buf_full` may only rise after a buffer write. The acknowledge outcome must select between holding SCL again and letting it go. Only the bench scenarios show the rest: address filtering (foreign address, write direction, an address cut short by a repeated START) and the exact byte values the master reads back MSB first. They also show the host-side flag sequence through several ACK/NACK transfers.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_HOLD,
    ST_TX,
    ST_TACK
  } eng_state_t;

  // Address byte hits when the upper seven bits match and the direction bit asks for a read.
  function automatic logic addr_hit(input logic [7:0] rx_byte, input logic [6:0] own);
    return (rx_byte[7:1] == own) && rx_byte[0];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_s = chain_q[STAGES-1];
  assign rise   = line_s & ~prev_q;
  assign fall   = ~line_s & prev_q;

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_steady_hi;

  // SCL high on this sample and the previous one (a fresh rise does not count).
  assign scl_steady_hi = scl_s & ~scl_rise;
  assign start_ev      = scl_steady_hi & sda_fall;
  assign stop_ev       = scl_steady_hi & sda_rise;

  // R2: a bus condition is only seen with SCL high on two samples
  a_r2_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> (scl_s && $past(scl_s)));

endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '1;
    else if (load)  sh_q <= load_data;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];

  // R7: a buffer write puts the top data bit on the shifter output
  a_r7_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(load_data[W-1])));

endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              rel_set,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              rw_flag,
  output logic              buf_full,
  output logic              irq_flag
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_ev, stop_ev;
  logic tx_msb, tx_load, tx_shift, irq_set, rel_ok;

  eng_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, buf_q;
  logic              ack_q, full_q, rw_q, irq_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .line_s(scl_s), .rise(scl_rise), .fall(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .line_s(sda_s), .rise(sda_rise), .fall(sda_fall));

  i2c_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  assign tx_load  = buf_wr && (state_q == ST_HOLD);
  assign tx_shift = (state_q == ST_TX) && scl_fall && (cnt_q != LAST_BIT);
  assign irq_set  = scl_fall && ((state_q == ST_AACK) || (state_q == ST_TACK));
  assign rel_ok   = rel_set && full_q;

  i2c_tx_shifter #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(buf_wdata),
    .shift(tx_shift), .msb(tx_msb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      buf_q   <= '0;
      ack_q   <= 1'b1;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (tx_load) begin
        buf_q  <= buf_wdata;
        full_q <= 1'b1;
      end

      if (start_ev) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        rw_q    <= 1'b0;
        full_q  <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        rw_q    <= 1'b0;
        full_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && (cnt_q == FULL_CNT)) begin
              cnt_q <= '0;
              if (addr_hit(rx_q, own_addr)) begin
                state_q <= ST_AACK;
                buf_q   <= rx_q;
                rw_q    <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) state_q <= ST_HOLD;
          ST_HOLD: begin
            if (rel_ok) begin
              state_q <= ST_TX;
              cnt_q   <= '0;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                state_q <= ST_TACK;
                full_q  <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) ack_q <= sda_s;
            else if (scl_fall) begin
              if (ack_q) begin
                state_q <= ST_IDLE;
                rw_q    <= 1'b0;
                full_q  <= 1'b0;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_drive_low = (state_q == ST_HOLD);
  assign sda_drive_low = (state_q == ST_AACK) || ((state_q == ST_TX) && !tx_msb);
  assign buf_rdata     = buf_q;
  assign rw_flag       = rw_q;
  assign buf_full      = full_q;
  assign irq_flag      = irq_q;

  // R9: SDA only moves while SCL is low, unless a bus condition aborted the transfer
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> (!scl_s || $past(start_ev || stop_ev)));

  // R8: the interrupt only rises on a falling SCL edge
  a_r8_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(scl_fall));

  // R6: the stretch persists until a qualified release
  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !(rel_set && buf_full)) |=> scl_drive_low);

  // R7: buf_full only rises after a buffer write
  a_r7_full_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(buf_wr));

  // R4: a matched read records a read direction in the buffer
  a_r4_rw_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_flag) |-> ($past(scl_fall) && buf_rdata[0]));

  // R10: acknowledged byte leads to a new stretch
  a_r10_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TACK) && scl_fall && !ack_q) |=> scl_drive_low);

  // R11: not-acknowledged byte frees SCL and the status
  a_r11_nack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TACK) && scl_fall && ack_q) |=> (!scl_drive_low && !rw_flag && !buf_full));

endmodule

// File: tb/test_i2c_rd_slave.sv
module test_i2c_rd_slave;
  localparam int HALF = 25;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_drive_low, sda_drive_low;
  logic       buf_wr, rel_set, irq_clr;
  logic [7:0] buf_wdata, buf_rdata;
  logic       rw_flag, buf_full, irq_flag;
  logic       scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_drive_low);
  assign sda_line = !(m_sda_low || sda_drive_low);

  i2c_rd_slave i_i2c_rd_slave (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rel_set(rel_set), .irq_clr(irq_clr),
    .buf_rdata(buf_rdata), .rw_flag(rw_flag), .buf_full(buf_full), .irq_flag(irq_flag));

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] host_data [4];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- master side ----------------
  task automatic m_start();
    m_sda_low = 1'b0; waitc(HALF);
    m_scl_low = 1'b0; waitc(HALF);
    m_sda_low = 1'b1; waitc(HALF);
    m_scl_low = 1'b1; waitc(5);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; waitc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(HALF);
    m_sda_low = 1'b0; waitc(HALF);
  endtask

  task automatic m_write_bit(input logic b);
    m_sda_low = !b; waitc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(HALF);
    m_scl_low = 1'b1; waitc(5);
  endtask

  task automatic m_read_bit(output logic b);
    m_sda_low = 1'b0; waitc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    waitc(HALF / 2);
    b = sda_line;
    waitc(HALF - HALF / 2);
    m_scl_low = 1'b1; waitc(5);
  endtask

  task automatic m_write_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_write_bit(v[i]);
  endtask

  // monitor: reads one data byte, then compares against the scoreboard
  task automatic m_read_data(input logic give_ack);
    logic [7:0] v;
    logic       b;
    logic [7:0] e;
    for (int i = 7; i >= 0; i--) begin
      m_read_bit(b);
      v[i] = b;
    end
    m_write_bit(!give_ack);
    if (exp_q.size() == 0) check("R9 no expected byte", v, 32'hDEAD);
    else begin
      e = exp_q.pop_front();
      check("R9 byte MSB first", v, e);
    end
  endtask

  task automatic m_read_txn(input int n);
    logic a;
    m_write_byte({OWN, 1'b1});
    m_read_bit(a);
    check("R3 address ACK pulls SDA low", a, 1'b0);
    for (int i = 0; i < n; i++) m_read_data(i < n - 1);
  endtask

  // ---------------- host side (driver) ----------------
  task automatic pulse_rel();
    rel_set = 1'b1; @(negedge clk); rel_set = 1'b0;
  endtask

  task automatic host_serve(input int n);
    for (int i = 0; i < n; i++) begin
      while (!irq_flag) @(negedge clk);
      waitc(8);
      if (i == 0) begin
        check("R5 SCL held after address", scl_drive_low, 1'b1);
        check("R4 rw_flag on match", rw_flag, 1'b1);
        check("R4 address in buffer", buf_rdata, {OWN, 1'b1});
        pulse_rel();
        waitc(20);
        check("R6 release ignored when empty", scl_drive_low, 1'b1);
      end else begin
        check("R10 SCL held after master ACK", scl_drive_low, 1'b1);
      end
      check("R7 buf_full clear before load", buf_full, 1'b0);
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      check("R8 irq cleared by host", irq_flag, 1'b0);
      buf_wdata = host_data[i];
      buf_wr = 1'b1; @(negedge clk); buf_wr = 1'b0;
      exp_q.push_back(host_data[i]);
      check("R7 buf_full after write", buf_full, 1'b1);
      waitc(15);
      check("R6 still held before release", scl_drive_low, 1'b1);
      pulse_rel();
      check("R6 released after rel_set", scl_drive_low, 1'b0);
    end
  endtask

  task automatic run_read(input int n);
    fork
      m_read_txn(n);
      host_serve(n);
    join
    waitc(10);
    check("R11 SCL free after NACK", scl_drive_low, 1'b0);
    check("R11 rw_flag cleared after NACK", rw_flag, 1'b0);
    check("R11 buf_full cleared", buf_full, 1'b0);
    check("R8 irq set on NACKed byte", irq_flag, 1'b1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
    buf_wr = 1'b0; rel_set = 1'b0; irq_clr = 1'b0; buf_wdata = '0;
    waitc(10);
    check("R1 SCL released in reset", scl_drive_low, 1'b0);
    rst_n = 1'b1;
    waitc(5);
    check("R1 SCL released", scl_drive_low, 1'b0);
    check("R1 SDA released", sda_drive_low, 1'b0);
    check("R1 flags clear", {rw_flag, buf_full, irq_flag}, 3'b000);

    // foreign address: no acknowledge, no interrupt
    m_start();
    m_write_byte({OWN ^ 7'h01, 1'b1});
    m_read_bit(a);
    check("R3 foreign address NACK", a, 1'b1);
    check("R8 no irq on foreign address", irq_flag, 1'b0);
    m_stop();

    // write direction on own address: no acknowledge
    m_start();
    m_write_byte({OWN, 1'b0});
    m_read_bit(a);
    check("R3 write direction NACK", a, 1'b1);
    check("R4 rw_flag stays 0", rw_flag, 1'b0);
    m_stop();

    // address cut short by repeated START, then a full read
    m_start();
    for (int i = 7; i >= 4; i--) m_write_bit(OWN[i-1]);
    m_start();
    host_data[0] = 8'hA5; host_data[1] = 8'h3C; host_data[2] = 8'h00;
    run_read(3);   // R2 restart after abort, R10 ACK path, R11 NACK path

    // second transfer after a STOP
    m_start();
    host_data[0] = 8'hFF; host_data[1] = 8'h5A; host_data[2] = 8'h81;
    run_read(3);

    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule